// File: doc/BRIEF.md
# SMI Enable and Status Register Window

This block is a small power-management register window reached over a 32-bit I/O port bus. It exposes two words: an SMI enable word that software programs to choose which events may raise a system-management interrupt, and an SMI status word that latches those events until the host clears them. The whole power-management region can be moved: a sideband load sets an I/O base, and the window answers only once that base is nonzero. The window then sits at a fixed offset inside the region.

Writes to the enable word pass through two filters. The first is a write mask held in a register. The mask resets to all ones, and a sideband load can narrow it. The second is a watchdog lock input that freezes the watchdog-enable bit. The reset value of the enable word depends on a system-management-mode support strap. Without that support, the APM-control enable bit comes out of reset set, which keeps the handler from being entered. A request output is raised whenever the global enable is on and any enabled status bit is pending.

Top module: `smi_regblk`

## Requirements
- R1: While the stored I/O base is zero, no access is claimed: `io_hit` stays low, `io_rdata` reads zero, and writes change nothing.
- R2: Loading a base keeps it with its low ALIGN_LOG2 (default 7) bits cleared. The enable word is then at base+SMI_OFS (default 0x30), and the status word is at base+SMI_OFS+4. An address at the previous base is no longer claimed.
- R3: Only accesses with `io_size` equal to 4 bytes are claimed. Any other size reads zero and writes nothing.
- R4: A claimed read at window offset 0 returns the enable word, and offset 4 returns the status word. Every other offset in the 8-byte window reads zero and ignores writes.
- R5: A claimed write at offset 0 sets the enable word to (old & ~mask) | (data & mask). The mask resets to all ones and takes `mask_value` on `mask_load`.
- R6: While `wdog_lock` is high, bit 13 (watchdog enable) of the enable word keeps its previous value on every write.
- R7: After reset the enable word is zero when `smm_supported` is high. When `smm_supported` is low, the enable word is 0x00000020 (bit 5, APM-control enable, set).
- R8: A high `evt[i]` sets status bit i at the next clock. Writing a one to bit i at offset 4 clears that bit at the next clock, unless `evt[i]` is high in the same cycle, in which case the bit stays set. Writes at offset 0 leave the status word unchanged.
- R9: `smi_req` is high exactly when enable bit 0 (global enable) is set and status AND enable is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smm_supported | input | 1 | Strap: system-management mode available |
| base_load | input | 1 | Load a new I/O base this cycle |
| base_value | input | ADDR_W | New I/O base (low bits ignored) |
| mask_load | input | 1 | Load a new enable write mask |
| mask_value | input | 32 | New enable write mask |
| wdog_lock | input | 1 | Watchdog lock; freezes enable bit 13 |
| evt | input | 32 | Event pulses, one per status bit |
| io_valid | input | 1 | Bus access present |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Byte address of access |
| io_size | input | 3 | Access size in bytes |
| io_wdata | input | 32 | Write data, little-endian |
| io_hit | output | 1 | Window claims the access |
| io_rdata | output | 32 | Read data, zero when not claimed |
| smi_req | output | 1 | SMI request level |

## Verification
The assertions assume that `wdog_lock`, `evt` and the sideband loads are synchronous to `clk` and steady across each rising edge. They also assume that `smm_supported` only changes while reset is asserted. The stimulus meets these conditions in two ways. First, it drives every input at the falling edge. Second, it changes the strap only inside a reset pulse. The pseudo-random phase keeps most accesses at the legal size and near the window, so that claimed writes, ignored offsets and same-cycle set/clear collisions all occur often.

// File: rtl/smi_pkg.sv
package smi_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned WIN_BYTES = 8;
   localparam logic [2:0]  ACC_WORD  = 3'd4;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      logic hit;
      logic sel_en;
      logic sel_sts;
      logic wr_en;
      logic clr_sts;
   } dec_t;

endpackage

// File: rtl/smi_io_decode.sv
module smi_io_decode
   import smi_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned ALIGN_LOG2 = 7,
   parameter int unsigned SMI_OFS    = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_load,
   input  logic [ADDR_W-1:0] base_value,
   input  logic              io_valid,
   input  logic              io_write,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [2:0]        io_size,
   output logic [ADDR_W-1:0] base_q,
   output dec_t              dec
);

   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_LOG2) - 1);
   localparam logic [ADDR_W-1:0] OFS_A    = ADDR_W'(SMI_OFS);
   localparam logic [ADDR_W-1:0] WIN_A    = ADDR_W'(WIN_BYTES);

   logic [ADDR_W-1:0] win_lo;
   logic [ADDR_W-1:0] rel;
   logic              in_win;
   logic              live;
   logic              size_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= '0;
      else if (base_load)
         base_q <= base_value & ~LOW_MASK;
   end

   always_comb begin
      win_lo  = base_q + OFS_A;
      rel     = io_addr - win_lo;
      in_win  = rel < WIN_A;
      live    = base_q != '0;
      size_ok = io_size == ACC_WORD;
      dec.hit     = io_valid & live & size_ok & in_win;
      dec.sel_en  = dec.hit & (rel[2:0] == 3'd0);
      dec.sel_sts = dec.hit & (rel[2:0] == 3'd4);
      dec.wr_en   = dec.sel_en & io_write;
      dec.clr_sts = dec.sel_sts & io_write;
   end

endmodule

// File: rtl/smi_en_reg.sv
module smi_en_reg
   import smi_pkg::*;
#(
   parameter int unsigned APMC_BIT    = 5,
   parameter int unsigned WDOG_EN_BIT = 13
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  smm_supported,
   input  logic  mask_load,
   input  word_t mask_value,
   input  logic  wdog_lock,
   input  logic  wr,
   input  word_t wdata,
   output word_t en_q,
   output word_t mask_q
);

   word_t rst_val;
   word_t lk_data;

   always_comb begin
      rst_val           = '0;
      rst_val[APMC_BIT] = ~smm_supported;
   end

   genvar b;
   generate
      for (b = 0; b < WORD_W; b++) begin : g_lk
         if (b == WDOG_EN_BIT) begin : g_frz
            assign lk_data[b] = wdog_lock ? en_q[b] : wdata[b];
         end else begin : g_pass
            assign lk_data[b] = wdata[b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '1;
      else if (mask_load)
         mask_q <= mask_value;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= rst_val;
      else if (wr)
         en_q <= (en_q & ~mask_q) | (lk_data & mask_q);
   end

endmodule

// File: rtl/smi_sts_reg.sv
module smi_sts_reg
   import smi_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  word_t evt,
   input  logic  clr,
   input  word_t clr_bits,
   output word_t sts_q
);

   genvar i;
   generate
      for (i = 0; i < WORD_W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sts_q[i] <= 1'b0;
            else if (evt[i])
               sts_q[i] <= 1'b1;
            else if (clr && clr_bits[i])
               sts_q[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/smi_regblk.sv
module smi_regblk
   import smi_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned ALIGN_LOG2  = 7,
   parameter int unsigned SMI_OFS     = 48,
   parameter int unsigned APMC_BIT    = 5,
   parameter int unsigned WDOG_EN_BIT = 13,
   parameter int unsigned GBL_EN_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smm_supported,
   input  logic              base_load,
   input  logic [ADDR_W-1:0] base_value,
   input  logic              mask_load,
   input  logic [31:0]       mask_value,
   input  logic              wdog_lock,
   input  logic [31:0]       evt,
   input  logic              io_valid,
   input  logic              io_write,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [2:0]        io_size,
   input  logic [31:0]       io_wdata,
   output logic              io_hit,
   output logic [31:0]       io_rdata,
   output logic              smi_req
);

   generate
      if (ALIGN_LOG2 < 3 || ALIGN_LOG2 >= ADDR_W) begin : g_bad_align
         $error("smi_regblk: ALIGN_LOG2 out of range");
      end
      if ((SMI_OFS % 4) != 0 || SMI_OFS + WIN_BYTES > (1 << ALIGN_LOG2)) begin : g_bad_ofs
         $error("smi_regblk: SMI_OFS must be word aligned and inside the region");
      end
      if (APMC_BIT >= WORD_W || WDOG_EN_BIT >= WORD_W || GBL_EN_BIT >= WORD_W) begin : g_bad_bit
         $error("smi_regblk: enable bit index out of range");
      end
   endgenerate

   dec_t              dec;
   logic [ADDR_W-1:0] base_q;
   word_t             en_q;
   word_t             mask_q;
   word_t             sts_q;

   smi_io_decode #(
      .ADDR_W     (ADDR_W),
      .ALIGN_LOG2 (ALIGN_LOG2),
      .SMI_OFS    (SMI_OFS)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_load  (base_load),
      .base_value (base_value),
      .io_valid   (io_valid),
      .io_write   (io_write),
      .io_addr    (io_addr),
      .io_size    (io_size),
      .base_q     (base_q),
      .dec        (dec)
   );

   smi_en_reg #(
      .APMC_BIT    (APMC_BIT),
      .WDOG_EN_BIT (WDOG_EN_BIT)
   ) u_en (
      .clk           (clk),
      .rst_n         (rst_n),
      .smm_supported (smm_supported),
      .mask_load     (mask_load),
      .mask_value    (mask_value),
      .wdog_lock     (wdog_lock),
      .wr            (dec.wr_en),
      .wdata         (io_wdata),
      .en_q          (en_q),
      .mask_q        (mask_q)
   );

   smi_sts_reg u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr      (dec.clr_sts),
      .clr_bits (io_wdata),
      .sts_q    (sts_q)
   );

   always_comb begin
      io_hit = dec.hit;
      if (dec.sel_en)
         io_rdata = en_q;
      else if (dec.sel_sts)
         io_rdata = sts_q;
      else
         io_rdata = '0;
      smi_req = en_q[GBL_EN_BIT] & (|(sts_q & en_q));
   end

endmodule

// File: rtl/smi_regblk_chk.sv
module smi_regblk_chk #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned WDOG_EN_BIT = 13,
   parameter int unsigned GBL_EN_BIT  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_valid,
   input logic [2:0]        io_size,
   input logic              io_hit,
   input logic [ADDR_W-1:0] base_q,
   input logic [31:0]       en_q,
   input logic [31:0]       mask_q,
   input logic [31:0]       sts_q,
   input logic [31:0]       evt,
   input logic              wdog_lock,
   input logic              smi_req
);

   assert_no_hit_zero_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q == '0) |-> !io_hit);

   assert_word_size_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && io_size != 3'd4) |-> !io_hit);

   assert_mask_holds_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((en_q ^ $past(en_q)) & ~$past(mask_q)) == 32'h0));

   assert_lock_freezes_wdog_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_lock |=> (en_q[WDOG_EN_BIT] == $past(en_q[WDOG_EN_BIT])));

   assert_event_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != 32'h0) |=> ((sts_q & $past(evt)) == $past(evt)));

   assert_req_needs_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> en_q[GBL_EN_BIT]);

   assert_req_when_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[GBL_EN_BIT] && ((sts_q & en_q) != 32'h0)) |-> smi_req);

endmodule

bind smi_regblk smi_regblk_chk #(
   .ADDR_W      (ADDR_W),
   .WDOG_EN_BIT (WDOG_EN_BIT),
   .GBL_EN_BIT  (GBL_EN_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_valid  (io_valid),
   .io_size   (io_size),
   .io_hit    (io_hit),
   .base_q    (base_q),
   .en_q      (en_q),
   .mask_q    (mask_q),
   .sts_q     (sts_q),
   .evt       (evt),
   .wdog_lock (wdog_lock),
   .smi_req   (smi_req)
);

// File: tb/sim_smi_regblk.sv
module sim_smi_regblk;

   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        smm_supported;
   logic        base_load;
   logic [15:0] base_value;
   logic        mask_load;
   logic [31:0] mask_value;
   logic        wdog_lock;
   logic [31:0] evt;
   logic        io_valid;
   logic        io_write;
   logic [15:0] io_addr;
   logic [2:0]  io_size;
   logic [31:0] io_wdata;
   logic        io_hit;
   logic [31:0] io_rdata;
   logic        smi_req;

   // stimulus held by the tasks
   logic        g_rst = 1'b0, g_smm = 1'b1, g_bl = 1'b0, g_ml = 1'b0, g_lock = 1'b0;
   logic [15:0] g_bv = '0;
   logic [31:0] g_mv = '0, g_evt = '0;

   // reference state
   logic [31:0] m_en, m_sts, m_mask;
   logic [15:0] m_base;

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   smi_regblk u0 (
      .clk(clk), .rst_n(rst_n), .smm_supported(smm_supported),
      .base_load(base_load), .base_value(base_value),
      .mask_load(mask_load), .mask_value(mask_value),
      .wdog_lock(wdog_lock), .evt(evt),
      .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
      .io_size(io_size), .io_wdata(io_wdata),
      .io_hit(io_hit), .io_rdata(io_rdata), .smi_req(smi_req)
   );

   function automatic int win_off();
      logic [15:0] rel;
      rel = io_addr - (m_base + 16'h0030);
      if (io_valid && io_size == 3'd4 && m_base != 16'h0 && rel < 16'd8)
         return int'(rel);
      return -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en   = smm_supported ? 32'h0 : 32'h0000_0020;
         m_sts  = 32'h0;
         m_mask = 32'hFFFF_FFFF;
         m_base = 16'h0;
      end else begin
         int off;
         logic [31:0] d;
         off = win_off();
         if (io_write && off == 4)
            m_sts = m_sts & ~io_wdata;
         m_sts = m_sts | evt;
         if (io_write && off == 0) begin
            d = io_wdata;
            if (wdog_lock) d[13] = m_en[13];
            m_en = (m_en & ~m_mask) | (d & m_mask);
         end
         if (mask_load) m_mask = mask_value;
         if (base_load) m_base = base_value & 16'hFF80;
      end
   end

   task automatic compare(string tag);
      int          off;
      logic [31:0] erd;
      logic        ereq;
      off  = win_off();
      erd  = (off == 0) ? m_en : (off == 4) ? m_sts : 32'h0;
      ereq = m_en[0] && ((m_sts & m_en) != 32'h0);
      nvec++;
      if (io_hit !== (off >= 0)) begin
         nbad++;
         $display("FAIL %s io_hit got %b exp %b", tag, io_hit, off >= 0);
      end
      if (io_rdata !== erd) begin
         nbad++;
         $display("FAIL %s io_rdata got %h exp %h", tag, io_rdata, erd);
      end
      if (smi_req !== ereq) begin
         nbad++;
         $display("FAIL %s smi_req got %b exp %b", tag, smi_req, ereq);
      end
   endtask

   task automatic vec(input logic v, input logic w, input logic [15:0] a,
                      input logic [2:0] sz, input logic [31:0] d, input string tag);
      @(negedge clk);
      rst_n = g_rst; smm_supported = g_smm;
      base_load = g_bl; base_value = g_bv;
      mask_load = g_ml; mask_value = g_mv;
      wdog_lock = g_lock; evt = g_evt;
      io_valid = v; io_write = w; io_addr = a; io_size = sz; io_wdata = d;
      g_bl = 1'b0; g_ml = 1'b0; g_evt = '0;
      #1 compare(tag);
   endtask

   task automatic rd(input logic [15:0] a, input string tag);
      vec(1'b1, 1'b0, a, 3'd4, 32'h0, tag);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
      vec(1'b1, 1'b1, a, 3'd4, d, tag);
   endtask

   task automatic idle(input string tag);
      vec(1'b0, 1'b0, 16'h0, 3'd4, 32'h0, tag);
   endtask

   initial begin
      rst_n = 1'b0; smm_supported = 1'b1; base_load = 0; base_value = 0;
      mask_load = 0; mask_value = 0; wdog_lock = 0; evt = 0;
      io_valid = 0; io_write = 0; io_addr = 0; io_size = 3'd4; io_wdata = 0;
      #(PERIOD * 150000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      // reset state, SMM supported
      g_rst = 0; g_smm = 1;
      idle("R7 reset"); idle("R7 reset");
      g_rst = 1;
      // R1: base zero, nothing claimed
      wr(16'h0030, 32'hFFFF_FFFF, "R1 write base0");
      rd(16'h0030, "R1 read base0");
      rd(16'h0034, "R1 read sts base0");
      // R2: load base with low garbage
      g_bv = 16'h1055; g_bl = 1; idle("R2 load");
      rd(16'h1030, "R7 en after reset supported");
      rd(16'h1034, "R2 sts addr");
      // R5: full mask write then restricted mask
      wr(16'h1030, 32'hA5A5_5A5A, "R5 full mask");
      rd(16'h1030, "R5 readback");
      g_mv = 32'h0000_FF00; g_ml = 1; idle("R5 mask load");
      wr(16'h1030, 32'h0000_0000, "R5 masked write");
      rd(16'h1030, "R5 masked readback");
      // R6: lock keeps bit 13
      g_mv = 32'hFFFF_FFFF; g_ml = 1; idle("R5 mask open");
      wr(16'h1030, 32'h0000_2000, "R6 set wdog en");
      g_lock = 1;
      wr(16'h1030, 32'h0000_0000, "R6 locked clear");
      rd(16'h1030, "R6 bit held");
      g_lock = 0;
      wr(16'h1030, 32'h0000_0000, "R6 unlocked clear");
      rd(16'h1030, "R6 bit cleared");
      // R3: wrong size
      vec(1'b1, 1'b1, 16'h1030, 3'd2, 32'h1234_5678, "R3 half write");
      vec(1'b1, 1'b0, 16'h1030, 3'd1, 32'h0, "R3 byte read");
      rd(16'h1030, "R3 unchanged");
      // R4: odd offsets
      wr(16'h1032, 32'hFFFF_FFFF, "R4 odd write");
      rd(16'h1032, "R4 odd read");
      rd(16'h1037, "R4 tail read");
      rd(16'h1038, "R4 past window");
      rd(16'h1030, "R4 unchanged");
      // R8: events, W1C, collision
      g_evt = 32'h0000_0013; idle("R8 events");
      rd(16'h1034, "R8 status set");
      wr(16'h1030, 32'h0000_0000, "R8 en write keeps sts");
      rd(16'h1034, "R8 status kept");
      wr(16'h1034, 32'h0000_0001, "R8 w1c");
      rd(16'h1034, "R8 after w1c");
      g_evt = 32'h0000_0002;
      wr(16'h1034, 32'h0000_0002, "R8 collision");
      rd(16'h1034, "R8 set wins");
      // R9: request
      wr(16'h1030, 32'h0000_0002, "R9 no global");
      idle("R9 no global idle");
      wr(16'h1030, 32'h0000_0003, "R9 global on");
      idle("R9 req up");
      wr(16'h1034, 32'hFFFF_FFFF, "R9 clear all");
      idle("R9 req down");
      // reset without SMM support
      g_rst = 0; g_smm = 0; idle("R7 reset unsupported");
      g_rst = 1; idle("R7 release");
      g_bv = 16'h2000; g_bl = 1; idle("R2 relocate");
      rd(16'h2030, "R7 apmc set");
      rd(16'h1030, "R2 old base gone");
      g_bv = 16'h1000; g_bl = 1; idle("R2 relocate back");
      rd(16'h2030, "R2 second base gone");
      rd(16'h1030, "R2 back");
      // pseudo-random phase
      r = 32'h1ACE_B00C;
      for (int k = 0; k < 600; k++) begin
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         g_lock = r[9];
         g_evt  = r & 32'h0100_0307 & {32{r[10]}};
         if (r[20:16] == 5'd0) begin g_mv = r ^ 32'h5555_0000; g_ml = 1; end
         vec(1'b1, r[0], 16'h102E + 16'(r[4:1]), (r[7:5] == 3'd0) ? 3'd2 : 3'd4,
             {r[31:11], r[10:0]} ^ 32'h0000_0001, "R4 random");
      end
      idle("R9 final");
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule